// File: doc/BRIEF.md
# PCI Locked Cache-Line Tracker

This block keeps track of a single 32-byte line of local memory that a PCI agent has locked through a lock sequence on the primary PCI bus. It stores which requester owns the lock and which line is locked. Every cycle it classifies each incoming access and tells the requesting interface whether to carry on, terminate with retry, or stall. The sources are the primary bus, a secondary PCI bus without a lock pin, and a set of local CPU/DMA requesters.

The block only makes decisions. The bus protocol timing and the memory data paths live elsewhere. Lock establishment, lock release and the per-source access requests arrive as abstract single-cycle inputs. All verdicts are combinational from the stored lock state and the present inputs. A release therefore takes effect in the very cycle it is signalled, and every stalled requester is let go together.

Top module: `lkt_tracker`

## Requirements
- R1: After synchronous reset `lock_active`, `lock_line` and `lock_owner` are all zero, and every source whose valid is low reports verdict NONE (2'd0).
- R2: A lock request (`lk_req`) while no lock is in effect raises `lk_grant` and keeps `lk_retry` low in the same cycle. On the next cycle `lock_active` is 1, `lock_line` equals `lk_addr[ADDR_W-1:5]` and `lock_owner` equals `lk_id`.
- R3: The line match uses only address bits from bit 5 upward (32-byte lines). Any of the 32 byte offsets inside the locked line is a hit.
- R4: While a lock is in effect, a primary-bus access that hits the locked line with `pa_id` different from the owner reports RETRY (2'd2).
- R5: While a lock is in effect, a primary-bus access that hits the locked line with `pa_id` equal to the owner reports GO (2'd1).
- R6: While a lock is in effect, a secondary-bus access that hits the locked line reports HOLD (2'd3).
- R7: While a lock is in effect, a local requester access that hits the locked line reports HOLD (2'd3).
- R8: A valid access from any source that misses the locked line, or that arrives while no lock is in effect, reports GO (2'd1).
- R9: In the cycle `lk_rel` is high, the lock is treated as gone and all hitting accesses report GO. On the next cycle `lock_active`, `lock_line` and `lock_owner` are zero.
- R10: A lock request from a non-owner while a lock is in effect raises `lk_retry`, leaves `lk_grant` low and leaves the stored line and owner unchanged.
- R11: A lock request from the owner while a lock is in effect is granted and moves the lock to the newly addressed line.
- R12: When `lk_rel` and `lk_req` are high together, the request is granted, whoever sends it, and the new lock is in effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lock sequence request on the primary bus |
| lk_id | input | ID_W | Requester ID of the lock request |
| lk_addr | input | ADDR_W | Byte address of the lock request |
| lk_rel | input | 1 | Lock release |
| lk_grant | output | 1 | Lock request accepted this cycle |
| lk_retry | output | 1 | Lock request refused this cycle |
| pa_vld | input | 1 | Primary-bus access valid |
| pa_id | input | ID_W | Primary-bus requester ID |
| pa_addr | input | ADDR_W | Primary-bus byte address |
| pa_verdict | output | 2 | Primary verdict: 0 none, 1 go, 2 retry, 3 hold |
| sa_vld | input | 1 | Secondary-bus access valid |
| sa_addr | input | ADDR_W | Secondary-bus byte address |
| sa_verdict | output | 2 | Secondary verdict |
| lc_vld | input | N_LOCAL | Local requester valids |
| lc_addr | input | N_LOCAL*ADDR_W | Local requester addresses, requester k in slice k |
| lc_verdict | output | 2*N_LOCAL | Local verdicts, requester k in bits [2k+1:2k] |
| lock_active | output | 1 | A lock is stored |
| lock_line | output | ADDR_W-5 | Stored line address |
| lock_owner | output | ID_W | Stored owner ID |

## Verification
The bench builds the tracker with an 8-bit address, 2-bit IDs and two local requesters. That leaves eight lines and four requester IDs. With this size, every line can be locked by every owner. Under each of these locks, all 256 addresses are swept across every source and every primary ID, so every byte offset, every neighbouring line and both owner and non-owner cases are covered. The release cycle, non-owner and owner re-lock, and release together with a new request are then driven from hitting addresses.

// File: rtl/lkt_pkg.sv
package lkt_pkg;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_GO    = 2'd1,
        V_RETRY = 2'd2,
        V_HOLD  = 2'd3
    } verdict_e;

    typedef enum logic {
        SRC_LOCKBUS = 1'b0,
        SRC_STALL   = 1'b1
    } src_kind_e;

    function automatic verdict_e classify(input src_kind_e kind, input logic vld,
                                          input logic hit, input logic is_owner);
        verdict_e v;
        if (!vld)
            v = V_NONE;
        else if (!hit)
            v = V_GO;
        else if (kind == SRC_STALL)
            v = V_HOLD;
        else if (is_owner)
            v = V_GO;
        else
            v = V_RETRY;
        return v;
    endfunction

endpackage

// File: rtl/lkt_lock_reg.sv
module lkt_lock_reg #(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int LINE_BYTES = 32,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rel,
    output logic              grant,
    output logic              deny,
    output logic              eff_act,
    output logic              act_q,
    output logic [LINE_W-1:0] line_q,
    output logic [ID_W-1:0]   owner_q
);
    logic unused_ofs;
    logic own_match;

    assign unused_ofs = ^req_addr[OFS_W-1:0];

    always_comb begin
        eff_act   = act_q & ~rel;
        own_match = (req_id == owner_q);
        grant     = req & (~eff_act | own_match);
        deny      = req & ~grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            line_q  <= '0;
            owner_q <= '0;
        end else if (grant) begin
            act_q   <= 1'b1;
            line_q  <= req_addr[ADDR_W-1:OFS_W];
            owner_q <= req_id;
        end else if (rel) begin
            act_q   <= 1'b0;
            line_q  <= '0;
            owner_q <= '0;
        end
    end
endmodule

// File: rtl/lkt_line_match.sv
module lkt_line_match #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] line,
    input  logic              armed,
    output logic              hit
);
    logic unused_ofs;
    assign unused_ofs = ^addr[OFS_W-1:0];
    assign hit = armed && (addr[ADDR_W-1:OFS_W] == line);
endmodule

// File: rtl/lkt_src_verdict.sv
module lkt_src_verdict #(
    parameter int ID_W                  = 4,
    parameter lkt_pkg::src_kind_e KIND  = lkt_pkg::SRC_LOCKBUS
) (
    input  logic            vld,
    input  logic            hit,
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] owner,
    output logic [1:0]      verdict
);
    import lkt_pkg::*;
    logic is_owner;
    assign is_owner = (id == owner);
    assign verdict  = classify(KIND, vld, hit, is_owner);
endmodule

// File: rtl/lkt_tracker.sv
module lkt_tracker #(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int LINE_BYTES = 32,
    parameter int N_LOCAL    = 2,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lk_req,
    input  logic [ID_W-1:0]           lk_id,
    input  logic [ADDR_W-1:0]         lk_addr,
    input  logic                      lk_rel,
    output logic                      lk_grant,
    output logic                      lk_retry,
    input  logic                      pa_vld,
    input  logic [ID_W-1:0]           pa_id,
    input  logic [ADDR_W-1:0]         pa_addr,
    output logic [1:0]                pa_verdict,
    input  logic                      sa_vld,
    input  logic [ADDR_W-1:0]         sa_addr,
    output logic [1:0]                sa_verdict,
    input  logic [N_LOCAL-1:0]        lc_vld,
    input  logic [N_LOCAL*ADDR_W-1:0] lc_addr,
    output logic [2*N_LOCAL-1:0]      lc_verdict,
    output logic                      lock_active,
    output logic [LINE_W-1:0]         lock_line,
    output logic [ID_W-1:0]           lock_owner
);
    import lkt_pkg::*;

    logic eff_act;
    logic pa_hit;
    logic sa_hit;

    lkt_lock_reg #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LINE_BYTES(LINE_BYTES)) u_lock (
        .clk(clk), .rst(rst), .req(lk_req), .req_id(lk_id), .req_addr(lk_addr),
        .rel(lk_rel), .grant(lk_grant), .deny(lk_retry), .eff_act(eff_act),
        .act_q(lock_active), .line_q(lock_line), .owner_q(lock_owner)
    );

    lkt_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_pa_match (
        .addr(pa_addr), .line(lock_line), .armed(eff_act), .hit(pa_hit)
    );

    lkt_src_verdict #(.ID_W(ID_W), .KIND(SRC_LOCKBUS)) u_pa_verdict (
        .vld(pa_vld), .hit(pa_hit), .id(pa_id), .owner(lock_owner), .verdict(pa_verdict)
    );

    lkt_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sa_match (
        .addr(sa_addr), .line(lock_line), .armed(eff_act), .hit(sa_hit)
    );

    lkt_src_verdict #(.ID_W(ID_W), .KIND(SRC_STALL)) u_sa_verdict (
        .vld(sa_vld), .hit(sa_hit), .id(lock_owner), .owner(lock_owner), .verdict(sa_verdict)
    );

    for (genvar g = 0; g < N_LOCAL; g++) begin : g_local
        logic hit;
        lkt_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_match (
            .addr(lc_addr[g*ADDR_W +: ADDR_W]), .line(lock_line), .armed(eff_act), .hit(hit)
        );
        lkt_src_verdict #(.ID_W(ID_W), .KIND(SRC_STALL)) u_verdict (
            .vld(lc_vld[g]), .hit(hit), .id(lock_owner), .owner(lock_owner),
            .verdict(lc_verdict[2*g +: 2])
        );
    end
endmodule

// File: rtl/lkt_tracker_chk.sv
module lkt_tracker_chk #(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int LINE_BYTES = 32,
    parameter int N_LOCAL    = 2,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      lk_req,
    input logic [ID_W-1:0]           lk_id,
    input logic [ADDR_W-1:0]         lk_addr,
    input logic                      lk_rel,
    input logic                      lk_grant,
    input logic                      lk_retry,
    input logic                      pa_vld,
    input logic [ID_W-1:0]           pa_id,
    input logic [ADDR_W-1:0]         pa_addr,
    input logic [1:0]                pa_verdict,
    input logic                      sa_vld,
    input logic [ADDR_W-1:0]         sa_addr,
    input logic [1:0]                sa_verdict,
    input logic [N_LOCAL-1:0]        lc_vld,
    input logic [N_LOCAL*ADDR_W-1:0] lc_addr,
    input logic [2*N_LOCAL-1:0]      lc_verdict,
    input logic                      lock_active,
    input logic [LINE_W-1:0]         lock_line,
    input logic [ID_W-1:0]           lock_owner
);
    logic [LINE_W-1:0] req_line;
    assign req_line = lk_addr[ADDR_W-1:OFS_W];

    // R2
    grant_captures_chk: assert property (@(posedge clk) disable iff (rst)
        lk_grant |=> lock_active && lock_owner == $past(lk_id) && lock_line == $past(req_line));

    // R10
    grant_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lk_grant && lk_retry));

    // R10
    foreign_lock_refused_chk: assert property (@(posedge clk) disable iff (rst)
        lk_retry |=> $stable(lock_line) && $stable(lock_owner));

    // R9
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        lk_rel && !lk_req |=> !lock_active && lock_line == '0 && lock_owner == '0);

    // R4
    primary_retry_chk: assert property (@(posedge clk) disable iff (rst)
        pa_vld && lock_active && !lk_rel && pa_addr[ADDR_W-1:OFS_W] == lock_line
        && pa_id != lock_owner |-> pa_verdict == 2'd2);

    // R6
    secondary_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sa_verdict == 2'd3 |-> sa_vld && lock_active && !lk_rel
        && sa_addr[ADDR_W-1:OFS_W] == lock_line);

    // R8
    idle_go_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_active && pa_vld |-> pa_verdict == 2'd1);

    for (genvar g = 0; g < N_LOCAL; g++) begin : g_lc
        // R7
        local_hold_chk: assert property (@(posedge clk) disable iff (rst)
            lc_vld[g] && lock_active && !lk_rel
            && lc_addr[g*ADDR_W+OFS_W +: LINE_W] == lock_line |-> lc_verdict[2*g +: 2] == 2'd3);
    end
endmodule

bind lkt_tracker lkt_tracker_chk #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .LINE_BYTES(LINE_BYTES), .N_LOCAL(N_LOCAL)
) u_chk (.*);

// File: tb/sim_lkt_tracker.sv
`timescale 1ns/1ps
module sim_lkt_tracker;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int NL = 2;
    localparam int LW = AW - 5;

    logic clk = 1'b0;
    logic rst;
    logic lk_req, lk_rel;
    logic [IW-1:0] lk_id;
    logic [AW-1:0] lk_addr;
    logic lk_grant, lk_retry;
    logic pa_vld, sa_vld;
    logic [IW-1:0] pa_id;
    logic [AW-1:0] pa_addr, sa_addr;
    logic [1:0] pa_verdict, sa_verdict;
    logic [NL-1:0] lc_vld;
    logic [NL*AW-1:0] lc_addr;
    logic [2*NL-1:0] lc_verdict;
    logic lock_active;
    logic [LW-1:0] lock_line;
    logic [IW-1:0] lock_owner;

    int total = 0;
    int bad = 0;

    bit m_act = 0;
    int m_line = 0;
    int m_own = 0;

    always #4 clk = ~clk;

    lkt_tracker #(.ADDR_W(AW), .ID_W(IW), .LINE_BYTES(32), .N_LOCAL(NL)) u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_v(bit stall, bit vld, int addr, int id, bit rel_now);
        bit hit;
        if (!vld) return 0;
        hit = m_act && !rel_now && ((addr >> 5) == m_line);
        if (!hit) return 1;
        if (stall) return 3;
        return (id == m_own) ? 1 : 2;
    endfunction

    task automatic check_state(input string tag);
        check({tag, " active"}, int'(lock_active), int'(m_act));
        check({tag, " line"}, int'(lock_line), m_line);
        check({tag, " owner"}, int'(lock_owner), m_own);
    endtask

    task automatic set_all(input int a, input int id);
        pa_vld = 1; sa_vld = 1; lc_vld = '1;
        pa_addr = AW'(a); pa_id = IW'(id);
        sa_addr = AW'(a);
        lc_addr = {AW'(a ^ 32), AW'(a)};
    endtask

    task automatic check_all(input string tag, input bit rel_now);
        check({tag, " R4/R5 primary"}, int'(pa_verdict),
              exp_v(0, pa_vld, int'(pa_addr), int'(pa_id), rel_now));
        check({tag, " R6 secondary"}, int'(sa_verdict), exp_v(1, sa_vld, int'(sa_addr), 0, rel_now));
        check({tag, " R7 local0"}, int'(lc_verdict[1:0]),
              exp_v(1, lc_vld[0], int'(lc_addr[AW-1:0]), 0, rel_now));
        check({tag, " R7 local1"}, int'(lc_verdict[3:2]),
              exp_v(1, lc_vld[1], int'(lc_addr[2*AW-1:AW]), 0, rel_now));
    endtask

    task automatic do_lock(input int a, input int id, input string tag);
        bit expect_grant;
        lk_req = 1; lk_addr = AW'(a); lk_id = IW'(id);
        #1;
        expect_grant = !(m_act && !lk_rel) || (id == m_own);
        check({tag, " grant"}, int'(lk_grant), int'(expect_grant));
        check({tag, " retry"}, int'(lk_retry), int'(!expect_grant));
        step;
        lk_req = 0;
        if (expect_grant) begin
            m_act = 1; m_line = a >> 5; m_own = id;
        end else if (lk_rel) begin
            m_act = 0; m_line = 0; m_own = 0;
        end
        lk_rel = 0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; lk_req = 0; lk_rel = 0; lk_id = '0; lk_addr = '0;
        pa_vld = 0; sa_vld = 0; lc_vld = '0; pa_id = '0; pa_addr = '0;
        sa_addr = '0; lc_addr = '0;
        step; step;
        rst = 0;
        #1;
        // R1 reset state
        check_state("R1 reset");
        check_all("R1 idle", 0);

        // R8 no lock: everything goes
        for (int a = 0; a < 256; a += 7) begin
            set_all(a, a % 4);
            #1;
            check_all("R8 unlocked", 0);
        end
        pa_vld = 0; sa_vld = 0; lc_vld = '0;

        // R12 release while idle has no effect
        lk_rel = 1;
        step;
        lk_rel = 0;
        #1;
        check_state("R12 idle release");

        for (int ln = 0; ln < 8; ln++) begin
            for (int ow = 0; ow < 4; ow++) begin
                // R2 establish, offset varies with line
                do_lock(ln * 32 + ((ln * 5 + ow) % 32), ow, "R2 lock");
                // R3/R4/R5/R6/R7/R8 full sweep
                for (int a = 0; a < 256; a++) begin
                    for (int id = 0; id < 4; id++) begin
                        set_all(a, id);
                        #1;
                        check_all("R3 sweep", 0);
                    end
                end
                // R10 non-owner lock refused
                do_lock(((ln + 3) % 8) * 32, (ow + 1) % 4, "R10 foreign lock");
                // R9 release with hitting accesses
                set_all(ln * 32 + 31, (ow + 2) % 4);
                lk_rel = 1;
                #1;
                check_all("R9 release cycle", 1);
                step;
                lk_rel = 0;
                m_act = 0; m_line = 0; m_own = 0;
                #1;
                check_state("R9 cleared");
                check_all("R9 after", 0);
                pa_vld = 0; sa_vld = 0; lc_vld = '0;
            end
        end

        // R11 owner relocks a different line
        do_lock(40, 1, "R11 first");
        do_lock(200, 1, "R11 move");
        set_all(41, 0);
        #1;
        check_all("R11 old line free", 0);
        set_all(205, 0);
        #1;
        check_all("R11 new line", 0);

        // R12 release and foreign request together
        lk_rel = 1;
        do_lock(100, 3, "R12 rel+req");
        set_all(99, 1);
        #1;
        check_all("R12 new lock", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule